// File: doc/BRIEF.md
# Timer DMA Burst Register Access Unit

This unit lets one DMA channel refresh a run of neighbouring timer registers through a single fixed access point. Software sets a five-bit starting register offset, a burst length and a trigger-source bit. When the chosen timer event occurs, the unit raises its DMA request. It holds the request until the programmed number of transfers has passed through the window. Each window access is steered to the register at the starting offset plus a running index. The index starts at zero for every accepted burst.

A typical use is to change the period and the pulse width of a waveform together. The starting offset then points at the period register (offset 11), which is the lower of the two addresses, and the burst length is two. The timer core and the DMA engine sit outside the block. A small parameterised register file stands in for the timer registers, and it can also be reached directly by offset.

Top module: `tmr_dma_burst`

## Requirements
- R1: After reset, dma_req_o is 0, the configuration fields are 0 and every register reads 0.
- R2: With trig_sel 0, a one-cycle pulse on cc_evt_i while idle drives dma_req_o high from the next cycle. A pulse on upd_evt_i alone does not.
- R3: With trig_sel 1, a pulse on upd_evt_i while idle starts a burst. A pulse on cc_evt_i alone does not.
- R4: The k-th window access of a burst (k counted from 0) reads or writes the register at offset base + k.
- R5: The length field holds the transfer count minus one. dma_req_o stays high until the (len+1)-th window access and is low in the cycle after it.
- R6: A length field above 17 is clamped, which gives 18 transfers.
- R7: A trigger event that arrives while a burst is unfinished is ignored. The index does not restart and the burst length is unchanged.
- R8: A register offset at or beyond NUM_REGS reads 0 and ignores writes, whether it is reached directly or through the window.
- R9: A direct access (acc_win_i = 0) addresses acc_addr_i and does not advance the burst index.
- R10: With base 11 and length field 1, two window writes update registers 11 and 12, the period and pulse-width pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load the configuration fields |
| cfg_base_i | input | 5 | Starting register offset |
| cfg_len_i | input | 5 | Transfer count minus one |
| cfg_sel_i | input | 1 | Trigger source: 0 capture/compare, 1 update |
| cc_evt_i | input | 1 | Capture/compare event pulse |
| upd_evt_i | input | 1 | Update event pulse |
| acc_valid_i | input | 1 | Register access this cycle |
| acc_win_i | input | 1 | 1: burst window access, 0: direct access |
| acc_addr_i | input | 5 | Direct access register offset |
| acc_we_i | input | 1 | 1: write, 0: read |
| acc_wdata_i | input | 16 | Write data |
| acc_rdata_o | output | 16 | Read data for the current access, combinational |
| dma_req_o | output | 1 | DMA request |

## Verification
The assertions assume that accesses come one per cycle, and that the DMA side makes window accesses only in response to the request. They also assume that the configuration is not rewritten while a burst is in flight, and that trigger events are single-cycle pulses. The stimulus keeps to these assumptions. It drives every input on the falling edge and changes the configuration only while the request is low. It raises events only as isolated pulses, and it injects the deliberately ignored event in an idle cycle between two window accesses of a live burst.

// File: rtl/tmr_dma_burst_pkg.sv
package tmr_dma_burst_pkg;
  localparam int unsigned OFS_W    = 5;
  localparam int unsigned EFF_W    = OFS_W + 1;
  localparam int unsigned MAX_XFER = 18;
  localparam int unsigned LEN_MAX  = MAX_XFER - 1;

  typedef enum logic {TRIG_CC = 1'b0, TRIG_UPD = 1'b1} trig_sel_e;

  typedef struct packed {
    logic [OFS_W-1:0] base;
    logic [OFS_W-1:0] len;
    trig_sel_e        sel;
  } burst_cfg_t;
endpackage

// File: rtl/tmr_dma_burst_ctrl.sv
module tmr_dma_burst_ctrl
  import tmr_dma_burst_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  burst_cfg_t       cfg_i,
  input  logic             cc_evt_i,
  input  logic             upd_evt_i,
  input  logic             win_acc_i,
  output burst_cfg_t       cfg_o,
  output logic [OFS_W-1:0] idx_o,
  output logic             active_o
);
  burst_cfg_t       cfg_q;
  logic [OFS_W-1:0] idx_q;
  logic [OFS_W-1:0] len_eff;
  logic             active_q;
  logic             trig;

  always_comb begin
    len_eff = (cfg_q.len > OFS_W'(LEN_MAX)) ? OFS_W'(LEN_MAX) : cfg_q.len;
    trig    = (cfg_q.sel == TRIG_UPD) ? upd_evt_i : cc_evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_i;
  end

  // events are ignored while a burst is open
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (active_q) begin
      if (win_acc_i) begin
        if (idx_q == len_eff) active_q <= 1'b0;
        else                  idx_q    <= idx_q + 1'b1;
      end
    end else if (trig) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end
  end

  assign cfg_o    = cfg_q;
  assign idx_o    = idx_q;
  assign active_o = active_q;
endmodule

// File: rtl/tmr_dma_burst_regs.sv
module tmr_dma_burst_regs #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 20,
  parameter int unsigned ADDR_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= '0;
      else if (we_i && addr_i == ADDR_W'(g)) regs_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr_i == ADDR_W'(i)) rdata_o = regs_q[i];
  end
endmodule

// File: rtl/tmr_dma_burst.sv
module tmr_dma_burst
  import tmr_dma_burst_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [OFS_W-1:0]  cfg_base_i,
  input  logic [OFS_W-1:0]  cfg_len_i,
  input  logic              cfg_sel_i,
  input  logic              cc_evt_i,
  input  logic              upd_evt_i,
  input  logic              acc_valid_i,
  input  logic              acc_win_i,
  input  logic [OFS_W-1:0]  acc_addr_i,
  input  logic              acc_we_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  output logic [DATA_W-1:0] acc_rdata_o,
  output logic              dma_req_o
);
  burst_cfg_t       cfg_in, cfg_q;
  logic [OFS_W-1:0] idx;
  logic             active;
  logic             win_acc;
  logic [EFF_W-1:0] eff_addr;

  assign cfg_in  = '{base: cfg_base_i, len: cfg_len_i, sel: trig_sel_e'(cfg_sel_i)};
  assign win_acc = acc_valid_i & acc_win_i;

  tmr_dma_burst_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_we_i  (cfg_we_i),
    .cfg_i     (cfg_in),
    .cc_evt_i  (cc_evt_i),
    .upd_evt_i (upd_evt_i),
    .win_acc_i (win_acc),
    .cfg_o     (cfg_q),
    .idx_o     (idx),
    .active_o  (active)
  );

  assign eff_addr = acc_win_i ? (EFF_W'(cfg_q.base) + EFF_W'(idx)) : EFF_W'(acc_addr_i);

  tmr_dma_burst_regs #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (EFF_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (acc_valid_i & acc_we_i),
    .addr_i  (eff_addr),
    .wdata_i (acc_wdata_i),
    .rdata_o (acc_rdata_o)
  );

  assign dma_req_o = active;
endmodule

// File: rtl/tmr_dma_burst_chk.sv
module tmr_dma_burst_chk
  import tmr_dma_burst_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cc_evt_i,
  input logic              upd_evt_i,
  input logic              sel_q,
  input logic              acc_valid_i,
  input logic              acc_win_i,
  input logic              dma_req_o,
  input logic [OFS_W-1:0]  idx,
  input logic [EFF_W-1:0]  eff_addr,
  input logic [DATA_W-1:0] acc_rdata_o
);
  logic win;
  assign win = acc_valid_i & acc_win_i;

  p_req_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dma_req_o) |-> $past(sel_q ? upd_evt_i : cc_evt_i));

  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o && !win |=> dma_req_o);

  p_req_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dma_req_o) |-> $past(win));

  p_idx_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o && !win |=> $stable(idx));

  p_idx_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx <= OFS_W'(LEN_MAX));

  p_oor_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && eff_addr >= EFF_W'(NUM_REGS) |-> acc_rdata_o == '0);
endmodule

bind tmr_dma_burst tmr_dma_burst_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cc_evt_i    (cc_evt_i),
  .upd_evt_i   (upd_evt_i),
  .sel_q       (cfg_q.sel),
  .acc_valid_i (acc_valid_i),
  .acc_win_i   (acc_win_i),
  .dma_req_o   (dma_req_o),
  .idx         (idx),
  .eff_addr    (eff_addr),
  .acc_rdata_o (acc_rdata_o)
);

// File: tb/tmr_dma_burst_tb.sv
module tmr_dma_burst_tb;
  localparam int T        = 10;
  localparam int DATA_W   = 16;
  localparam int NUM_REGS = 20;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cfg_we_i = 0, cfg_sel_i = 0;
  logic [4:0]        cfg_base_i = 0, cfg_len_i = 0, acc_addr_i = 0;
  logic              cc_evt_i = 0, upd_evt_i = 0;
  logic              acc_valid_i = 0, acc_win_i = 0, acc_we_i = 0;
  logic [DATA_W-1:0] acc_wdata_i = 0;
  logic [DATA_W-1:0] acc_rdata_o;
  logic              dma_req_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DATA_W-1:0] mdl [NUM_REGS];
  int                exp_q[$];
  string             tag_q[$];

  always #(T/2) clk_i = ~clk_i;

  tmr_dma_burst #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_dut (.*);

  task automatic check(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic clr();
    cfg_we_i = 0; cc_evt_i = 0; upd_evt_i = 0;
    acc_valid_i = 0; acc_win_i = 0; acc_we_i = 0;
  endtask

  task automatic cfg(input int base, input int len, input bit sel);
    @(negedge clk_i); clr();
    cfg_we_i = 1; cfg_base_i = 5'(base); cfg_len_i = 5'(len); cfg_sel_i = sel;
  endtask

  task automatic evt(input bit cc, input bit upd);
    @(negedge clk_i); clr();
    cc_evt_i = cc; upd_evt_i = upd;
  endtask

  // driver: one access, expected read data goes to the scoreboard
  task automatic acc(input bit win, input int addr, input bit we, input int wd,
                     input int exp, input string tag);
    @(negedge clk_i); clr();
    acc_valid_i = 1; acc_win_i = win; acc_addr_i = 5'(addr);
    acc_we_i = we; acc_wdata_i = DATA_W'(wd);
    if (!we) begin exp_q.push_back(exp); tag_q.push_back(tag); end
  endtask

  task automatic chk_req(input bit exp, input string tag);
    @(negedge clk_i); clr();
    #2 check(int'(dma_req_o), int'(exp), tag);
  endtask

  // monitor
  initial forever begin
    @(negedge clk_i); #2;
    if (acc_valid_i && !acc_we_i) begin
      if (exp_q.size() == 0) check(1, 0, "scoreboard underflow");
      else check(int'(acc_rdata_o), exp_q.pop_front(), tag_q.pop_front());
    end
  end

  function automatic int rd_exp(input int a);
    return (a < NUM_REGS) ? int'(mdl[a]) : 0;
  endfunction

  initial begin
    #(T*100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NUM_REGS; i++) mdl[i] = '0;
    #(T*3) rst_ni = 1;
    // R1 reset state
    chk_req(0, "R1 req after reset");
    acc(0, 11, 0, 0, 0, "R1 reg reset value");
    // preload via direct writes
    for (int i = 0; i < NUM_REGS; i++) begin
      acc(0, i, 1, 16'h100 + i, 0, "");
      mdl[i] = DATA_W'(16'h100 + i);
    end
    acc(0, 25, 1, 16'hdead, 0, "");
    acc(0, 25, 0, 0, 0, "R8 direct out-of-range read");
    acc(0, 5, 0, 0, rd_exp(5), "R9 direct read");

    // R2, R10: cc trigger, base 11, two transfers
    cfg(11, 1, 0);
    evt(0, 1);
    chk_req(0, "R2 update event ignored when sel=0");
    evt(1, 0);
    chk_req(1, "R2 cc event raises request");
    acc(1, 0, 1, 16'h0aaa, 0, ""); mdl[11] = 16'h0aaa;
    chk_req(1, "R5 request held mid burst");
    acc(1, 0, 1, 16'h0bbb, 0, ""); mdl[12] = 16'h0bbb;
    chk_req(0, "R5 request drops after len+1 accesses");
    acc(0, 11, 0, 0, 16'h0aaa, "R10 period register written");
    acc(0, 12, 0, 0, 16'h0bbb, "R10 pulse register written");
    acc(0, 13, 0, 0, rd_exp(13), "R4 neighbour untouched");

    // R3, R4, R7, R9: update trigger, base 2, four transfers
    cfg(2, 3, 1);
    evt(1, 0);
    chk_req(0, "R3 cc event ignored when sel=1");
    evt(0, 1);
    chk_req(1, "R3 update event raises request");
    acc(1, 0, 0, 0, rd_exp(2), "R4 window index 0");
    acc(0, 9, 0, 0, rd_exp(9), "R9 direct read mid burst");
    acc(1, 0, 0, 0, rd_exp(3), "R9 index not advanced by direct access");
    evt(0, 1);
    chk_req(1, "R7 request still high");
    acc(1, 0, 0, 0, rd_exp(4), "R7 event mid burst did not restart index");
    acc(1, 0, 0, 0, rd_exp(5), "R4 window index 3");
    chk_req(0, "R7 burst length unchanged by mid-burst event");

    // R6: clamp to 18 transfers
    cfg(0, 31, 0);
    evt(1, 0);
    for (int k = 0; k < 18; k++) begin
      acc(1, 0, 0, 0, rd_exp(k), "R6 clamped burst read");
      if (k == 16) chk_req(1, "R6 request before final transfer");
    end
    chk_req(0, "R6 request drops after 18 transfers");

    // R8: window out of range
    cfg(19, 1, 0);
    evt(1, 0);
    acc(1, 0, 1, 16'h0555, 0, ""); mdl[19] = 16'h0555;
    acc(1, 0, 1, 16'h0666, 0, "");
    chk_req(0, "R8 burst ended");
    acc(0, 19, 0, 0, 16'h0555, "R8 in-range window write lands");
    evt(1, 0);
    acc(1, 0, 0, 0, rd_exp(19), "R8 window index 0 read");
    acc(1, 0, 0, 0, 0, "R8 window beyond last register reads zero");
    chk_req(0, "R8 second burst ended");

    @(negedge clk_i); clr();
    @(negedge clk_i);
    if (exp_q.size() != 0) check(exp_q.size(), 0, "scoreboard leftovers");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule